// File: doc/BRIEF.md
# CEC Receive Frame Queue

This block sits between a bus-level CEC receiver and a host register port. The receiver hands over each complete frame in a single cycle: a header byte, an opcode byte, up to fourteen operand bytes, an operand count and an error flag. The queue stores each frame as one unit in a small circular buffer. It presents the oldest frame to the host through word-addressed registers.

The host first reads a packed status word to see how many frames are waiting. It then reads the header, the opcode and the operands of the oldest frame. To release that frame it writes a self-clearing discard bit, or it empties the whole queue with a self-clearing flush. A maskable interrupt tells the host that frames have arrived. A sticky overflow flag records any frame that was lost because the queue was full.

Register word map (`reg_addr_i`):

| Address | Register | Contents |
|---|---|---|
| 0 | status | bits 3:0 = head operand count, bits 6:4 = frames held, bit 7 = head error |
| 1 | control | bit 0 = discard head, bits 1:0 = 11 to flush |
| 2 | interrupt status | bit 1 = not empty, bit 3 = overflow; write 1 to clear |
| 3 | interrupt enable | bit 1 = not empty, bit 3 = overflow |
| 4 | header | header byte of the head frame |
| 5 | opcode | opcode byte of the head frame |
| 6 to 19 | operands | operand bytes 0 to 13 of the head frame |

Top module: `cec_rx_queue`

## Requirements
- R1: An accepted frame adds one to the frame count in status bits 6:4. Status bits 3:0 give the head frame's operand count. Status bit 7 gives the head frame's error flag.
- R2: Frames leave in arrival order. The header reads at address 4, the opcode at address 5, and operand i at address 6+i.
- R3: The queue holds 4 frames. A frame that arrives while 4 are held is dropped and the count does not change. The drop sets interrupt status bit 3, which stays set until the host writes 1 to that bit.
- R4: Writing control with bit 0 = 1 and bit 1 = 0 discards the head frame. Control bit 0 reads 1 for exactly one cycle, and the discard is complete one clock after the write.
- R5: Writing control = 0x3 empties the queue. Control reads 0x3 for one cycle and then 0. The flush also clears interrupt status bit 1. Writing control = 0x2 has no effect.
- R6: A frame that carries the error flag takes a slot like any other frame and is released by a normal discard.
- R7: Interrupt status bit 1 sets when a frame is accepted. Writing 1 to that bit clears it. It sets again when a discard leaves frames behind. `irq_o` is the OR of the interrupt status bits ANDed with their enables in interrupt enable bits 1 and 3.
- R8: While the queue is empty, the header, opcode and operand registers read 0. An operand address at or beyond the head frame's operand count also reads 0.
- R9: After reset the queue is empty, control reads 0 and `irq_o` is low.
- R10: An operand count above 14 from the receiver is stored as 14.
- R11: A frame that arrives in the same cycle a flush executes is discarded and is not counted as an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | A complete frame is presented this cycle |
| rx_hdr_i | input | 8 | Header byte |
| rx_opc_i | input | 8 | Opcode byte |
| rx_opd_i | input | 112 | Operand bytes; operand i occupies bits 8i+7:8i |
| rx_cnt_i | input | 4 | Operand count |
| rx_err_i | input | 1 | Frame was received with an error |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check a set of rules on every cycle. The frame count never exceeds the depth, and a push into a full queue leaves the count unchanged. A flush always leaves the queue empty. Discard and flush requests clear themselves after one cycle. An accepted frame always sets the not-empty flag, and the overflow flag stays set until the host clears it. The empty-queue read rule is also checked on every cycle. Only the bench scenarios can show that frame contents come back intact and in order, that counts above 14 are clamped, that the interrupt sets again after a partial drain, and that a push colliding with a flush is discarded.

// File: rtl/cec_rxq_pkg.sv
package cec_rxq_pkg;
  localparam int OPD_MAX = 14;
  localparam int BYTE_W  = 8;

  typedef struct packed {
    logic                              err;
    logic [3:0]                        cnt;
    logic [BYTE_W-1:0]                 hdr;
    logic [BYTE_W-1:0]                 opc;
    logic [OPD_MAX-1:0][BYTE_W-1:0]    opd;
  } frame_t;

  localparam logic [4:0] A_STATUS = 5'd0;
  localparam logic [4:0] A_CTRL   = 5'd1;
  localparam logic [4:0] A_ISTAT  = 5'd2;
  localparam logic [4:0] A_IEN    = 5'd3;
  localparam logic [4:0] A_HDR    = 5'd4;
  localparam logic [4:0] A_OPC    = 5'd5;
  localparam logic [4:0] A_OPD    = 5'd6;
endpackage

// File: rtl/cec_rxq_store.sv
module cec_rxq_store
  import cec_rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  frame_t           frame_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output frame_t           head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             pushed_o,
  output logic             dropped_o,
  output logic             popped_o
);
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, empty, push_ok, pop_ok;
  frame_t           slot_w [DEPTH];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push_i & ~full & ~flush_i;
  assign pop_ok  = pop_i & ~empty & ~flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
      else if (!push_ok && pop_ok) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    frame_t q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= '0;
      else if (push_ok && wr_q == PTR_W'(g)) q <= frame_i;
    end
    assign slot_w[g] = q;
  end

  assign head_o    = empty ? '0 : slot_w[rd_q];
  assign count_o   = cnt_q;
  assign pushed_o  = push_ok;
  assign dropped_o = push_i & full & ~flush_i;
  assign popped_o  = pop_ok;

  // R1: occupancy never exceeds depth
  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R3: a push into a full queue without a pop leaves the count alone
  a_r3_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !pop_i && !flush_i) |=> cnt_q == $past(cnt_q));
  // R5: flush always empties
  a_r5_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> cnt_q == '0);
endmodule

// File: rtl/cec_rxq_regs.sv
module cec_rxq_regs
  import cec_rxq_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [4:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  frame_t           head_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             pushed_i,
  input  logic             dropped_i,
  input  logic             popped_i,
  output logic [7:0]       rdata_o,
  output logic             irq_o,
  output logic             pop_o,
  output logic             flush_o
);
  logic       pop_q, flush_q, ne_q, ovf_q, en_ne_q, en_ovf_q;
  logic       ctrl_wr, pop_req, flush_req, clr_ne, clr_ovf, set_ne;
  logic [4:0] opd_idx;

  // a new request is taken only when none is in flight
  assign ctrl_wr   = we_i & (addr_i == A_CTRL) & ~pop_q & ~flush_q;
  assign flush_req = ctrl_wr & (&wdata_i[1:0]);
  assign pop_req   = ctrl_wr & wdata_i[0] & ~wdata_i[1];
  assign clr_ne    = we_i & (addr_i == A_ISTAT) & wdata_i[1];
  assign clr_ovf   = we_i & (addr_i == A_ISTAT) & wdata_i[3];
  assign set_ne    = pushed_i | (popped_i & (count_i > CNT_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pop_q    <= 1'b0;
      flush_q  <= 1'b0;
      ne_q     <= 1'b0;
      ovf_q    <= 1'b0;
      en_ne_q  <= 1'b0;
      en_ovf_q <= 1'b0;
    end else begin
      pop_q   <= pop_req;
      flush_q <= flush_req;
      if (flush_q)     ne_q <= 1'b0;
      else if (set_ne) ne_q <= 1'b1;
      else if (clr_ne) ne_q <= 1'b0;
      if (dropped_i)    ovf_q <= 1'b1;
      else if (clr_ovf) ovf_q <= 1'b0;
      if (we_i && addr_i == A_IEN) begin
        en_ne_q  <= wdata_i[1];
        en_ovf_q <= wdata_i[3];
      end
    end
  end

  assign pop_o   = pop_q;
  assign flush_o = flush_q;
  assign irq_o   = (ne_q & en_ne_q) | (ovf_q & en_ovf_q);
  assign opd_idx = addr_i - A_OPD;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_STATUS: rdata_o = {head_i.err, 3'(count_i), head_i.cnt};
      A_CTRL:   rdata_o = {6'd0, flush_q, flush_q | pop_q};
      A_ISTAT:  rdata_o = {4'd0, ovf_q, 1'b0, ne_q, 1'b0};
      A_IEN:    rdata_o = {4'd0, en_ovf_q, 1'b0, en_ne_q, 1'b0};
      A_HDR:    rdata_o = head_i.hdr;
      A_OPC:    rdata_o = head_i.opc;
      default:
        if (addr_i >= A_OPD && opd_idx < 5'(OPD_MAX) && opd_idx < {1'b0, head_i.cnt})
          rdata_o = head_i.opd[opd_idx[3:0]];
    endcase
  end

  // R4: a discard request lasts one cycle
  a_r4_pop_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_q |=> !pop_q);
  // R5: a flush request lasts one cycle
  a_r5_flush_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q |=> !flush_q);
  // R3: overflow flag is sticky until written 1
  a_r3_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !clr_ovf) |=> ovf_q);
  // R7: an accepted frame always raises not-empty
  a_r7_set_on_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pushed_i |=> ne_q);
  // R8: empty queue reads zero for frame fields
  a_r8_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == '0 && addr_i >= A_HDR) |-> rdata_o == 8'd0);
endmodule

// File: rtl/cec_rx_queue.sv
module cec_rx_queue
  import cec_rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rx_valid_i,
  input  logic [7:0]                rx_hdr_i,
  input  logic [7:0]                rx_opc_i,
  input  logic [OPD_MAX*BYTE_W-1:0] rx_opd_i,
  input  logic [3:0]                rx_cnt_i,
  input  logic                      rx_err_i,
  input  logic                      reg_we_i,
  input  logic [4:0]                reg_addr_i,
  input  logic [7:0]                reg_wdata_i,
  output logic [7:0]                reg_rdata_o,
  output logic                      irq_o
);
  frame_t           in_frame, head;
  logic [CNT_W-1:0] count;
  logic             pop, flush, pushed, dropped, popped;

  always_comb begin
    in_frame.err = rx_err_i;
    in_frame.cnt = (rx_cnt_i > 4'(OPD_MAX)) ? 4'(OPD_MAX) : rx_cnt_i;
    in_frame.hdr = rx_hdr_i;
    in_frame.opc = rx_opc_i;
    in_frame.opd = rx_opd_i;
  end

  cec_rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni,
    .push_i(rx_valid_i), .frame_i(in_frame), .pop_i(pop), .flush_i(flush),
    .head_o(head), .count_o(count),
    .pushed_o(pushed), .dropped_o(dropped), .popped_o(popped)
  );

  cec_rxq_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .head_i(head), .count_i(count),
    .pushed_i(pushed), .dropped_i(dropped), .popped_i(popped),
    .rdata_o(reg_rdata_o), .irq_o(irq_o), .pop_o(pop), .flush_o(flush)
  );
endmodule

// File: tb/sim_cec_rx_queue.sv
module sim_cec_rx_queue;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rx_valid = 1'b0;
  logic [7:0]   rx_hdr = '0, rx_opc = '0;
  logic [111:0] rx_opd = '0;
  logic [3:0]   rx_cnt = '0;
  logic         rx_err = 1'b0;
  logic         we = 1'b0;
  logic [4:0]   addr = '0;
  logic [7:0]   wdata = '0, rdata;
  logic         irq;
  int           checks = 0, fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  cec_rx_queue u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_hdr_i(rx_hdr),
    .rx_opc_i(rx_opc), .rx_opd_i(rx_opd), .rx_cnt_i(rx_cnt), .rx_err_i(rx_err),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  // {hdr, opc, cnt, err, operand seed}
  localparam logic [28:0] VEC [4] = '{
    {8'h40, 8'h04, 4'd0,  1'b0, 8'h00},
    {8'h4F, 8'h82, 4'd2,  1'b0, 8'h10},
    {8'h05, 8'h9F, 4'd14, 1'b1, 8'hA0},
    {8'h0F, 8'h36, 4'd15, 1'b0, 8'h30}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] h, input logic [7:0] o,
                      input logic [3:0] c, input logic e, input logic [7:0] s);
    @(negedge clk);
    rx_valid = 1'b1; rx_hdr = h; rx_opc = o; rx_cnt = c; rx_err = e;
    for (int i = 0; i < 14; i++) rx_opd[i*8 +: 8] = s + 8'(i);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  logic [7:0] v;

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    rd(5'd0, v); chk("R9 status", v, 0);
    rd(5'd1, v); chk("R9 ctrl", v, 0);
    chk("R9 irq", irq, 0);
    rd(5'd4, v); chk("R8 empty header", v, 0);
    rd(5'd6, v); chk("R8 empty operand", v, 0);

    // R1 fill from table
    for (int k = 0; k < 4; k++) begin
      push(VEC[k][28:21], VEC[k][20:13], VEC[k][12:9], VEC[k][8], VEC[k][7:0]);
      rd(5'd0, v); chk("R1 count", int'(v[6:4]), k + 1);
    end
    // R3 overflow
    push(8'hEE, 8'hEE, 4'd1, 1'b0, 8'hEE);
    rd(5'd0, v); chk("R3 count at full", int'(v[6:4]), 4);
    rd(5'd2, v); chk("R3 overflow flag", int'(v[3]), 1);

    // R2 drain in order, R6/R10 on the way
    for (int k = 0; k < 4; k++) begin
      int ec;
      ec = (VEC[k][12:9] > 4'd14) ? 14 : int'(VEC[k][12:9]);
      rd(5'd0, v);
      chk("R1 status cnt R10", int'(v[3:0]), ec);
      chk("R6 status err", int'(v[7]), int'(VEC[k][8]));
      chk("R1 status frames", int'(v[6:4]), 4 - k);
      rd(5'd4, v); chk("R2 header", v, int'(VEC[k][28:21]));
      rd(5'd5, v); chk("R2 opcode", v, int'(VEC[k][20:13]));
      for (int i = 0; i < 14; i++) begin
        rd(5'(6 + i), v);
        chk("R2 operand R8", v, (i < ec) ? int'(VEC[k][7:0] + 8'(i)) : 0);
      end
      wr(5'd1, 8'h01);
      rd(5'd1, v); chk("R4 pop pending", v, 1);
      @(negedge clk);
      rd(5'd1, v); chk("R4 pop cleared", v, 0);
    end
    rd(5'd0, v); chk("R4 drained", v, 0);
    rd(5'd2, v); chk("R3 overflow still set", int'(v[3]), 1);
    wr(5'd2, 8'h08);
    rd(5'd2, v); chk("R3 overflow cleared", int'(v[3]), 0);

    // R5 flush and partial write
    push(8'h11, 8'h22, 4'd1, 1'b0, 8'h33);
    push(8'h12, 8'h23, 4'd1, 1'b0, 8'h34);
    wr(5'd1, 8'h02);
    rd(5'd0, v); chk("R5 0x2 ignored", int'(v[6:4]), 2);
    rd(5'd1, v); chk("R5 0x2 ctrl", v, 0);
    wr(5'd1, 8'h03);
    rd(5'd1, v); chk("R5 flush pending", v, 3);
    @(negedge clk);
    rd(5'd1, v); chk("R5 flush cleared", v, 0);
    rd(5'd0, v); chk("R5 flushed count", v, 0);

    // R7 interrupt
    wr(5'd3, 8'h0A);
    chk("R7 irq idle", irq, 0);
    push(8'h21, 8'h01, 4'd0, 1'b0, 8'h00);
    chk("R7 irq on arrival", irq, 1);
    push(8'h22, 8'h02, 4'd0, 1'b0, 8'h00);
    wr(5'd2, 8'h02);
    chk("R7 irq cleared", irq, 0);
    wr(5'd1, 8'h01);
    @(negedge clk);
    chk("R7 irq after partial drain", irq, 1);
    rd(5'd4, v); chk("R7 head after pop", v, 8'h22);
    wr(5'd2, 8'h02);
    wr(5'd1, 8'h01);
    @(negedge clk);
    chk("R7 irq after last pop", irq, 0);

    // R11 push colliding with flush execution
    push(8'h31, 8'h01, 4'd0, 1'b0, 8'h00);
    @(negedge clk);
    we = 1'b1; addr = 5'd1; wdata = 8'h03;
    @(negedge clk);
    we = 1'b0;
    rx_valid = 1'b1; rx_hdr = 8'h99; rx_cnt = 4'd0;
    @(negedge clk);
    rx_valid = 1'b0;
    rd(5'd0, v); chk("R11 count after collision", v, 0);
    rd(5'd2, v); chk("R11 no overflow", v, 0);
    chk("R11 irq low", irq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule